// File: doc/BRIEF.md
# Counter-Ramp and Tracking Converter Controller

This block is the digital half of a counter-based analogue-to-digital converter. It drives a binary code to an external DAC and reads back one comparator bit. The bit is high while the analogue input is at or above the DAC output. One up/down counter drives the DAC code directly.

In ramp mode a start strobe clears the counter. The counter then climbs one step per clock until the comparator reports that the DAC has passed the input. At that point the count freezes, is copied to the result output and the done flag rises. In tracking mode the comparator steers the same counter up or down on every clock, so the code follows a moving input. In that mode the result follows the code and done stays high.

The comparator bit is asynchronous to the clock and passes through a two-flop synchroniser. After a clear, the sequencer waits for the synchroniser to refill before it judges the comparator.

Top module: `ramp_track_adc`

## Requirements
- R1: With the tracking select low, a start strobe sets the DAC code to 0 and drops the done flag at the next clock edge.
- R2: In a ramp, the counter holds for the two clocks after the clear. From then on it increments by one on each clock at which the synchronised comparator bit is 1.
- R3: In a ramp, at the first judged clock whose synchronised comparator bit is 0, the counter freezes. At that edge result takes the count and done goes high. Both stay unchanged until the next start strobe or tracking select.
- R4: A start strobe while a ramp runs, including in the clock at which the ramp would stop, restarts the ramp from code 0 with done low.
- R5: With the tracking select high, each clock counts up when the synchronised comparator bit is 1 and down when it is 0. After every such clock result equals the DAC code and done is 1. Start strobes are ignored in this mode.
- R6: The counter never wraps. A ramp that reaches all-ones stops there with done high. In tracking mode the code stays at all-ones or at 0 rather than wrapping.
- R7: The comparator value used at a clock edge is the comparator input as sampled two edges earlier.
- R8: The DAC code output always equals the counter. After reset the code and result are 0 and done is 0.
- R9: Lowering the tracking select without a start strobe freezes the code and result and keeps done at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin or restart a ramp conversion (one-clock strobe) |
| track_i | input | 1 | 1 = tracking mode, 0 = ramp mode |
| cmp_i | input | 1 | Comparator bit: 1 when input is at or above DAC output |
| dac_code_o | output | WIDTH | Code driven to the external DAC |
| result_o | output | WIDTH | Converted value |
| done_o | output | 1 | Result valid |

## Verification
Two functions can meet at one clock edge: a fresh start strobe, and the judgement that stops a running ramp. A second pair is a start strobe arriving with the tracking select high. The bench predicts the stop edge from its own queue-based comparator model and raises start exactly at that edge. It then expects the code to return to 0 with done low, not a frozen result. For the second pair it toggles start throughout tracking and expects pure up/down steering.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAMP  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_TRACK = 2'd3
  } adc_state_e;

  typedef enum logic [1:0] {
    CNT_KEEP  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_UP    = 2'd2,
    CNT_DOWN  = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/adc_cmp_sync.sv
module adc_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb ff_d = d_i;
    end else begin : g_chain
      always_comb ff_d = {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/adc_code_counter.sv
module adc_code_counter
  import adc_ctrl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] cnt_d_o,
  output logic [WIDTH-1:0] cnt_q_o,
  output logic             at_max_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = '1;
  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (op_i)
      CNT_CLEAR: begin cnt_d = '0; cnt_en = 1'b1; end
      CNT_UP:    if (cnt_q != CNT_MAX) begin cnt_d = cnt_q + CNT_ONE; cnt_en = 1'b1; end
      CNT_DOWN:  if (cnt_q != '0)      begin cnt_d = cnt_q - CNT_ONE; cnt_en = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_d_o  = cnt_d;
  assign cnt_q_o  = cnt_q;
  assign at_max_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_ctrl_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    track_i,
  input  logic    cmp_s_i,
  input  logic    at_max_i,
  output cnt_op_e op_o,
  output logic    load_o,
  output logic    done_o
);

  localparam int            WW      = $clog2(SETTLE + 1);
  localparam logic [WW-1:0] WAIT_LIM = WW'(SETTLE);
  localparam logic [WW-1:0] WAIT_ONE = WW'(1);

  adc_state_e    state_q, state_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    op_o    = CNT_KEEP;
    load_o  = 1'b0;
    if (track_i) begin
      state_d = ST_TRACK;
      op_o    = cmp_s_i ? CNT_UP : CNT_DOWN;
      load_o  = 1'b1;
    end else if (start_i) begin
      state_d = ST_RAMP;
      op_o    = CNT_CLEAR;
      wait_d  = '0;
    end else begin
      unique case (state_q)
        ST_RAMP: begin
          if (wait_q != WAIT_LIM) begin
            wait_d = wait_q + WAIT_ONE;
          end else if (!cmp_s_i || at_max_i) begin
            state_d = ST_HOLD;
            load_o  = 1'b1;
          end else begin
            op_o = CNT_UP;
          end
        end
        ST_TRACK: state_d = ST_HOLD;
        default:  ;
      endcase
    end
    done_d = (state_d == ST_HOLD) || (state_d == ST_TRACK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/ramp_track_adc.sv
module ramp_track_adc
  import adc_ctrl_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             track_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             cmp_s;
  cnt_op_e          cnt_op;
  logic [WIDTH-1:0] cnt_d, cnt_q;
  logic             at_max;
  logic             load_res;
  logic [WIDTH-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  adc_cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  adc_conv_seq #(.SETTLE(SYNC_STAGES)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .start_i  (start_i),
    .track_i  (track_i),
    .cmp_s_i  (cmp_s),
    .at_max_i (at_max),
    .op_o     (cnt_op),
    .load_o   (load_res),
    .done_o   (done_o)
  );

  adc_code_counter #(.WIDTH(WIDTH)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .op_i     (cnt_op),
    .cnt_d_o  (cnt_d),
    .cnt_q_o  (cnt_q),
    .at_max_o (at_max)
  );

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)    result_q <= '0;
    else if (load_res) result_q <= cnt_d;
  end

  assign dac_code_o = cnt_q;
  assign result_o   = result_q;

endmodule

// File: rtl/adc_ctrl_checker.sv
module adc_ctrl_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             start_i,
  input logic             track_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             done_o
);

  localparam logic [WIDTH-1:0] CMAX = '1;
  localparam logic [WIDTH-1:0] CONE = WIDTH'(1);

  p_start_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !track_i) |=> (dac_code_o == '0 && !done_o));

  p_ramp_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!done_o && !track_i && !start_i && dac_code_o != CMAX) |=>
      (dac_code_o == $past(dac_code_o) || dac_code_o == $past(dac_code_o) + CONE));

  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !track_i && !start_i) |=>
      (done_o && $stable(dac_code_o) && $stable(result_o)));

  p_track_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    track_i |=> (done_o && result_o == dac_code_o));

  p_track_step_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (track_i && dac_code_o != CMAX && dac_code_o != '0) |=>
      (dac_code_o == $past(dac_code_o) + CONE || dac_code_o == $past(dac_code_o) - CONE));

  p_no_wrap_max_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dac_code_o == CMAX && !(start_i && !track_i)) |=> (dac_code_o != '0));

  p_no_wrap_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dac_code_o == '0 && track_i) |=> (dac_code_o != CMAX));

endmodule

bind ramp_track_adc adc_ctrl_checker #(.WIDTH(WIDTH)) i_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_int),
  .start_i    (start_i),
  .track_i    (track_i),
  .dac_code_o (dac_code_o),
  .result_o   (result_o),
  .done_o     (done_o)
);

// File: tb/test_ramp_track_adc.sv
module test_ramp_track_adc;

  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         track;
  logic         cmp;
  logic [W-1:0] dac_code;
  logic [W-1:0] result;
  logic         done;

  int vin;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R8";

  // reference model state: 0 idle, 1 ramp, 2 hold, 3 track
  bit model_on = 0;
  int m_code, m_res, m_state, m_wait;
  bit m_done;
  bit cq[$];

  always #4 clk = ~clk;

  assign cmp = (vin >= int'(dac_code));

  ramp_track_adc #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_ramp_track_adc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .track_i(track),
    .cmp_i(cmp), .dac_code_o(dac_code), .result_o(result), .done_o(done)
  );

  // R7: value used at an edge is the comparator from two edges earlier
  always @(posedge clk) begin
    bit cs;
    if (model_on) begin
      cs = cq.pop_front();
      cq.push_back(vin >= m_code);
      if (track) begin
        m_state = 3;
        if (cs) m_code = (m_code < MAXV) ? m_code + 1 : MAXV;
        else    m_code = (m_code > 0) ? m_code - 1 : 0;
        m_res = m_code;
      end else if (start) begin
        m_state = 1; m_code = 0; m_wait = 0;
      end else if (m_state == 1) begin
        if (m_wait < SYNC) m_wait++;
        else if (!cs || m_code == MAXV) begin m_state = 2; m_res = m_code; end
        else m_code++;
      end else if (m_state == 3) begin
        m_state = 2;
      end
      m_done = (m_state == 2 || m_state == 3);
    end
  end

  task automatic tick();
    @(negedge clk);
    checks++;
    if (int'(dac_code) != m_code || int'(result) != m_res || done != m_done) begin
      errors++;
      $display("FAIL %s: code=%0d res=%0d done=%0d expected code=%0d res=%0d done=%0d",
               tag, dac_code, result, done, m_code, m_res, m_done);
    end
  endtask

  task automatic run_ramp(input int v);
    vin = v;
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < 400 && !m_done; i++) tick();
    repeat (4) tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; track = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    m_code = 0; m_res = 0; m_state = 0; m_wait = 0; m_done = 0;
    cq.push_back(1'b1); cq.push_back(1'b1);
    model_on = 1;

    tag = "R8 reset state"; repeat (3) tick();

    tag = "R1 R2 R3 ramp to 37"; run_ramp(37);
    tag = "R3 hold ignores input"; vin = 200; repeat (6) tick();
    tag = "R7 ramp to 100 with sync lag"; run_ramp(100);
    tag = "R3 ramp with input 0"; run_ramp(0);
    tag = "R6 ramp saturates at max"; run_ramp(300);

    tag = "R4 restart mid ramp";
    vin = 150; start = 1'b1; tick(); start = 1'b0;
    repeat (20) tick();
    start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 400 && !m_done; i++) tick();

    tag = "R4 start in stop cycle";
    vin = 60; start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 400 && !(m_state == 1 && m_wait == SYNC &&
         (!cq[0] || m_code == MAXV)); i++) tick();
    start = 1'b1; tick(); start = 1'b0;
    checks++;
    if (dac_code != '0 || done) begin
      errors++;
      $display("FAIL R4: code=%0d done=%0d expected code=0 done=0", dac_code, done);
    end
    for (int i = 0; i < 400 && !m_done; i++) tick();

    tag = "R5 track with start ignored";
    track = 1'b1;
    for (int i = 0; i < 200; i++) begin
      vin = (i < 100) ? 90 : 40;
      start = i[0];
      tick();
    end
    start = 1'b0;
    tag = "R6 track floor at 0"; vin = -5; repeat (140) tick();
    tag = "R6 track ceiling at max"; vin = 400; repeat (300) tick();
    tag = "R5 track mid"; vin = 128; repeat (150) tick();

    tag = "R9 leave track"; track = 1'b0; vin = 10; repeat (8) tick();
    tag = "R1 R3 ramp after track"; run_ramp(50);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

endmodule